// File: doc/BRIEF.md
# Indirect register access bridge

This bridge lets a narrow host bus reach a much larger internal space of per-channel registers and per-channel filter RAMs. The host sees only a handful of direct addresses. Two of them form a 32-bit holding pair: a staging value for writes and a result value for reads. A third direct address starts an internal write of the staged value. A fourth starts an internal read whose result lands in the holding pair. A fifth reports status. Every internal transfer runs for a fixed number of clocks, and a busy flag is raised for that time.

Each channel has a control register whose top bit pauses the channel's filter engine. The filter RAM of a channel can only be reached by the host while that pause bit is set. When the pause bit is cleared, or when the host writes the channel's soft-reset register, the channel runs a timed internal reset and flags it on a per-channel output. The filter arithmetic is outside this block. The register file and RAM here are storage that stands in for it.

Internal address layout (16 bits written at direct address 2 or 3): bits [13:12] select the channel, bit 11 selects the filter RAM (1) or the register file (0), bits [4:0] give the register offset, and bits [5:0] give the RAM word index.

Top module: `ib_bridge`

## Requirements
- R1: A host read at direct address 0 returns bits [15:0] of the read-holding register, and a read at direct address 1 returns bits [31:16]. The value appears on host_rdata one clock after the read strobe. After hardware reset both halves read zero.
- R2: Host writes at direct address 0 (low half) and 1 (high half) stage a 32-bit value. A write at direct address 2 then stores it at the internal address given by the written word, and only that location changes.
- R3: A write at direct address 3 fetches the addressed internal word into the read-holding register. The word is valid at direct addresses 0 and 1 once busy has dropped.
- R4: busy rises on the clock that accepts a write at direct address 2 or 3, and stays high for exactly 4 clocks. The internal write or read completes on the clock where busy falls.
- R5: While busy is high, a host write to direct address 0, 1, 2 or 3 is dropped and sets a sticky error bit. Status is read at direct address 4: bit 0 busy, bit 1 error, bits [5:2] per-channel reset-busy. A host write to direct address 4 with bit 0 set clears the error.
- R6: ch_hold[c] equals bit 31 of register offset 0x00A of channel c. Writing that register sets or clears the hold.
- R7: While a channel's hold is clear, internal writes to its filter RAM are ignored and internal reads of it return zero. While hold is set, the RAM is written and read normally.
- R8: When a channel's hold goes from set to clear, ch_rst_busy for that channel is high for exactly 32 clocks, starting on the clock where the hold clears.
- R9: An internal write of any value to register offset 0x019 of a channel starts the same 32-clock reset for that channel.
- R10: Register offsets 0x010 to 0x01F are 16 bits wide. Internal writes to them keep only the low staged half, and reading them returns zero in bits [31:16].
- R11: Synchronous reset clears the holding registers, the hold bits, busy and the error bit. Every channel leaves reset in its 32-clock reset-busy period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_wr | input | 1 | Host write strobe |
| host_rd | input | 1 | Host read strobe |
| host_addr | input | 3 | Direct address |
| host_wdata | input | 16 | Host write data |
| host_rdata | output | 16 | Registered host read data |
| busy | output | 1 | Internal transfer in progress |
| ch_hold | output | 4 | Per-channel filter pause bits |
| ch_rst_busy | output | 4 | Per-channel timed reset in progress |

## Verification
The bench attacks the edges of the transfer window. It issues a holding write and a second transfer on the clocks straight after a start. A design that let these through would corrupt the staged word or lose the read in flight, and the error bit would stay clear. It reads the filter RAM both with hold clear and with hold set, so an ungated RAM shows up as stale data where zero is expected. It counts the reset-busy window after a hold release and after a soft reset, which catches an off-by-one timer or a trigger on the wrong edge of the hold bit. It also writes a narrow register with a full word, which exposes a high half that leaked into storage.

// File: rtl/ib_pkg.sv
package ib_pkg;
  // direct (host-visible) addresses
  localparam logic [2:0] DA_LO    = 3'd0;
  localparam logic [2:0] DA_HI    = 3'd1;
  localparam logic [2:0] DA_WADDR = 3'd2;
  localparam logic [2:0] DA_RADDR = 3'd3;
  localparam logic [2:0] DA_STAT  = 3'd4;

  // internal address field positions
  localparam int XA_CH_LSB = 12;
  localparam int XA_RAM_BIT = 11;

  typedef enum logic {XF_RD = 1'b0, XF_WR = 1'b1} xfer_kind_e;
endpackage

// File: rtl/ib_host_port.sv
module ib_host_port
  import ib_pkg::*;
#(
  parameter int XFER_CYC = 4,
  parameter int CH_N     = 4,
  parameter int XA_W     = 14
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            host_wr,
  input  logic            host_rd,
  input  logic [2:0]      host_addr,
  input  logic [15:0]     host_wdata,
  output logic [15:0]     host_rdata,
  input  logic [31:0]     rd_value,
  input  logic [CH_N-1:0] rst_busy,
  output logic            busy,
  output logic            err,
  output logic            commit_wr,
  output logic            commit_rd,
  output logic            ram_fetch,
  output logic [XA_W-1:0] xaddr,
  output logic [31:0]     whold
);
  localparam int CW = $clog2(XFER_CYC);
  localparam logic [CW-1:0] LAST = CW'(XFER_CYC - 1);

  logic [CW-1:0] cnt;
  xfer_kind_e    kind;
  logic [31:0]   rhold;
  logic          at_last;

  assign at_last   = busy && (cnt == LAST);
  assign commit_wr = at_last && (kind == XF_WR);
  assign commit_rd = at_last && (kind == XF_RD);
  assign ram_fetch = busy && (cnt == LAST - CW'(1)) && (kind == XF_RD);

  always_ff @(posedge clk) begin
    if (rst) begin
      busy       <= 1'b0;
      cnt        <= '0;
      kind       <= XF_RD;
      xaddr      <= '0;
      whold      <= '0;
      rhold      <= '0;
      err        <= 1'b0;
      host_rdata <= '0;
    end else begin
      if (busy) begin
        cnt <= cnt + CW'(1);
        if (cnt == LAST) busy <= 1'b0;
      end
      if (commit_rd) rhold <= rd_value;

      if (host_rd) begin
        case (host_addr)
          DA_LO:   host_rdata <= rhold[15:0];
          DA_HI:   host_rdata <= rhold[31:16];
          DA_STAT: host_rdata <= 16'({rst_busy, err, busy});
          default: host_rdata <= '0;
        endcase
      end

      if (host_wr) begin
        if (busy && (host_addr <= DA_RADDR)) begin
          err <= 1'b1; // R5: dropped while a transfer runs
        end else begin
          case (host_addr)
            DA_LO: whold[15:0]  <= host_wdata;
            DA_HI: whold[31:16] <= host_wdata;
            DA_WADDR, DA_RADDR: begin
              xaddr <= host_wdata[XA_W-1:0];
              kind  <= (host_addr == DA_WADDR) ? XF_WR : XF_RD;
              busy  <= 1'b1;
              cnt   <= '0;
            end
            DA_STAT: if (host_wdata[0]) err <= 1'b0;
            default: ;
          endcase
        end
      end
    end
  end
endmodule

// File: rtl/ib_chan_bank.sv
module ib_chan_bank #(
  parameter int CH_N        = 4,
  parameter int REG_N       = 32,
  parameter int RST_CYC     = 32,
  parameter int HOLD_OFS    = 10,
  parameter int SRST_OFS    = 25,
  parameter int NARROW_BASE = 16
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     wr_en,
  input  logic [$clog2(CH_N)-1:0]  ch_sel,
  input  logic [$clog2(REG_N)-1:0] ofs,
  input  logic [31:0]              wdata,
  output logic [31:0]              rd_q,
  output logic [CH_N-1:0]          hold,
  output logic [CH_N-1:0]          rst_busy
);
  localparam int CH_W = $clog2(CH_N);
  localparam int RW   = $clog2(REG_N);
  localparam int IW   = CH_W + RW;
  localparam int TW   = $clog2(RST_CYC + 1);

  logic [31:0]   regs [2**IW];
  logic [IW-1:0] idx;
  logic [31:0]   wval;

  assign idx  = {ch_sel, ofs};
  // R10: narrow registers keep the low half only
  assign wval = (ofs >= RW'(NARROW_BASE)) ? {16'h0, wdata[15:0]} : wdata;
  assign rd_q = regs[idx];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < 2**IW; i++) regs[i] <= '0;
    end else if (wr_en) begin
      regs[idx] <= wval;
    end
  end

  for (genvar c = 0; c < CH_N; c++) begin : g_chan
    logic [TW-1:0] tcnt;
    logic          hit, trig;

    assign hold[c] = regs[c * REG_N + HOLD_OFS][31]; // R6
    assign hit     = wr_en && (ch_sel == CH_W'(c));
    // R8 hold release, R9 soft reset register
    assign trig    = hit && (((ofs == RW'(HOLD_OFS)) && !wdata[31] && hold[c]) ||
                             (ofs == RW'(SRST_OFS)));

    always_ff @(posedge clk) begin
      if (rst || trig)   tcnt <= TW'(RST_CYC);
      else if (tcnt != 0) tcnt <= tcnt - TW'(1);
    end
    assign rst_busy[c] = (tcnt != '0);
  end
endmodule

// File: rtl/ib_coef_ram.sv
module ib_coef_ram #(
  parameter int CH_N  = 4,
  parameter int DEPTH = 64
) (
  input  logic                     clk,
  input  logic                     we,
  input  logic                     re,
  input  logic [$clog2(CH_N)-1:0]  ch_sel,
  input  logic [$clog2(DEPTH)-1:0] widx,
  input  logic [31:0]              wdata,
  output logic [31:0]              rq
);
  localparam int AW = $clog2(CH_N) + $clog2(DEPTH);

  logic [31:0]   mem [2**AW];
  logic [AW-1:0] a;

  assign a = {ch_sel, widx};

  always_ff @(posedge clk) begin
    if (we) mem[a] <= wdata;
    if (re) rq <= mem[a];
  end
endmodule

// File: rtl/ib_bridge.sv
module ib_bridge
  import ib_pkg::*;
#(
  parameter int CH_N        = 4,
  parameter int REG_N       = 32,
  parameter int RAM_DEPTH   = 64,
  parameter int XFER_CYC    = 4,
  parameter int RST_CYC     = 32,
  parameter int HOLD_OFS    = 10,
  parameter int SRST_OFS    = 25,
  parameter int NARROW_BASE = 16
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            host_wr,
  input  logic            host_rd,
  input  logic [2:0]      host_addr,
  input  logic [15:0]     host_wdata,
  output logic [15:0]     host_rdata,
  output logic            busy,
  output logic [CH_N-1:0] ch_hold,
  output logic [CH_N-1:0] ch_rst_busy
);
  localparam int CH_W = $clog2(CH_N);
  localparam int RW   = $clog2(REG_N);
  localparam int AW   = $clog2(RAM_DEPTH);
  localparam int XA_W = XA_CH_LSB + CH_W;

  logic [XA_W-1:0] xaddr;
  logic [31:0]     whold, rd_value, reg_q, ram_q;
  logic            commit_wr, commit_rd, ram_fetch, err_flag;
  logic [CH_W-1:0] ch;
  logic            is_ram, hold_sel;
  logic            unused_xa;

  assign ch        = xaddr[XA_CH_LSB +: CH_W];
  assign is_ram    = xaddr[XA_RAM_BIT];
  assign hold_sel  = ch_hold[ch];
  assign unused_xa = ^xaddr[XA_RAM_BIT-1:AW];
  // R7: RAM reads outside hold return zero
  assign rd_value  = is_ram ? (hold_sel ? ram_q : 32'h0) : reg_q;

  ib_host_port #(.XFER_CYC(XFER_CYC), .CH_N(CH_N), .XA_W(XA_W)) port_i (
    .clk(clk), .rst(rst), .host_wr(host_wr), .host_rd(host_rd),
    .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .rd_value(rd_value), .rst_busy(ch_rst_busy), .busy(busy), .err(err_flag),
    .commit_wr(commit_wr), .commit_rd(commit_rd), .ram_fetch(ram_fetch),
    .xaddr(xaddr), .whold(whold)
  );

  ib_chan_bank #(
    .CH_N(CH_N), .REG_N(REG_N), .RST_CYC(RST_CYC), .HOLD_OFS(HOLD_OFS),
    .SRST_OFS(SRST_OFS), .NARROW_BASE(NARROW_BASE)
  ) bank_i (
    .clk(clk), .rst(rst), .wr_en(commit_wr && !is_ram), .ch_sel(ch),
    .ofs(xaddr[RW-1:0]), .wdata(whold), .rd_q(reg_q),
    .hold(ch_hold), .rst_busy(ch_rst_busy)
  );

  ib_coef_ram #(.CH_N(CH_N), .DEPTH(RAM_DEPTH)) ram_i (
    .clk(clk), .we(commit_wr && is_ram && hold_sel),
    .re(ram_fetch && is_ram), .ch_sel(ch), .widx(xaddr[AW-1:0]),
    .wdata(whold), .rq(ram_q)
  );
endmodule

// File: rtl/ib_bridge_chk.sv
module ib_bridge_chk #(
  parameter int XFER_CYC = 4,
  parameter int CH_N     = 4
) (
  input logic            clk,
  input logic            rst,
  input logic            host_wr,
  input logic [2:0]      host_addr,
  input logic            clr_bit,
  input logic            busy,
  input logic            err,
  input logic [CH_N-1:0] ch_hold,
  input logic [CH_N-1:0] ch_rst_busy
);
  int blen;
  always_ff @(posedge clk) begin
    if (rst)       blen <= 0;
    else if (busy) blen <= blen + 1;
    else           blen <= 0;
  end

  assert_busy_short_R4: assert property (@(posedge clk) disable iff (rst)
    busy |-> (blen < XFER_CYC));
  assert_busy_full_R4: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> (blen == XFER_CYC));
  assert_drop_sets_err_R5: assert property (@(posedge clk) disable iff (rst)
    (busy && host_wr && (host_addr <= 3'd3)) |=> err);
  assert_err_sticky_R5: assert property (@(posedge clk) disable iff (rst)
    (err && !(host_wr && (host_addr == 3'd4) && clr_bit)) |=> err);
  assert_reset_clear_R11: assert property (@(posedge clk)
    $fell(rst) |-> (!busy && !err && (ch_hold == '0) && (ch_rst_busy == '1)));

  for (genvar c = 0; c < CH_N; c++) begin : g_ch
    assert_release_reset_R8: assert property (@(posedge clk) disable iff (rst)
      $fell(ch_hold[c]) |-> ch_rst_busy[c]);
  end
endmodule

bind ib_bridge ib_bridge_chk #(.XFER_CYC(XFER_CYC), .CH_N(CH_N)) chk_i (
  .clk(clk), .rst(rst), .host_wr(host_wr), .host_addr(host_addr),
  .clr_bit(host_wdata[0]), .busy(busy), .err(err_flag),
  .ch_hold(ch_hold), .ch_rst_busy(ch_rst_busy)
);

// File: tb/ib_bridge_tb.sv
module ib_bridge_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        host_wr = 1'b0, host_rd = 1'b0;
  logic [2:0]  host_addr = '0;
  logic [15:0] host_wdata = '0;
  logic [15:0] host_rdata;
  logic        busy;
  logic [3:0]  ch_hold, ch_rst_busy;

  int checks = 0, failures = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ib_bridge dut_i (
    .clk(clk), .rst(rst), .host_wr(host_wr), .host_rd(host_rd),
    .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .busy(busy), .ch_hold(ch_hold), .ch_rst_busy(ch_rst_busy)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  logic [31:0] m_regs [4][32];
  logic [31:0] m_ram  [4][64];
  int          m_rst  [4];
  logic [31:0] m_wh, m_rh;
  logic [15:0] m_xa;
  logic [15:0] m_rdata;
  bit          m_busy, m_err, m_wr, ob;
  int          m_cnt, mc, mo, mi;
  logic [3:0]  m_rb;

  function automatic logic [3:0] m_hold();
    for (int c = 0; c < 4; c++) m_hold[c] = m_regs[c][10][31];
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      for (int c = 0; c < 4; c++) begin
        for (int r = 0; r < 32; r++) m_regs[c][r] = '0;
        m_rst[c] = 32;
      end
      m_wh = '0; m_rh = '0; m_xa = '0; m_rdata = '0;
      m_busy = 0; m_err = 0; m_wr = 0; m_cnt = 0;
    end else begin
      for (int c = 0; c < 4; c++) m_rb[c] = (m_rst[c] > 0);
      if (host_rd) begin
        case (host_addr)
          3'd0: m_rdata = m_rh[15:0];
          3'd1: m_rdata = m_rh[31:16];
          3'd4: m_rdata = 16'({m_rb, m_err, m_busy});
          default: m_rdata = '0;
        endcase
      end
      for (int c = 0; c < 4; c++) if (m_rst[c] > 0) m_rst[c]--;
      ob = m_busy;
      if (ob && m_cnt == 3) begin
        m_busy = 0;
        mc = (m_xa >> 12) & 3; mo = m_xa & 31; mi = m_xa & 63;
        if (m_xa[11]) begin
          if (m_wr) begin
            if (m_hold()[mc]) m_ram[mc][mi] = m_wh;
          end else m_rh = m_hold()[mc] ? m_ram[mc][mi] : 32'h0;
        end else if (m_wr) begin
          if ((mo == 10 && !m_wh[31] && m_hold()[mc]) || mo == 25) m_rst[mc] = 32;
          m_regs[mc][mo] = (mo >= 16) ? (m_wh & 32'hFFFF) : m_wh;
        end else m_rh = m_regs[mc][mo];
      end else if (ob) m_cnt++;
      if (host_wr) begin
        if (ob && host_addr <= 3) m_err = 1;
        else case (host_addr)
          3'd0: m_wh[15:0]  = host_wdata;
          3'd1: m_wh[31:16] = host_wdata;
          3'd2, 3'd3: begin
            m_xa = host_wdata; m_wr = (host_addr == 3'd2);
            m_busy = 1; m_cnt = 0;
          end
          3'd4: if (host_wdata[0]) m_err = 0;
          default: ;
        endcase
      end
    end
  end

  // per-clock comparison, away from the active edge
  always @(negedge clk) begin
    if (!rst) begin
      for (int c = 0; c < 4; c++) m_rb[c] = (m_rst[c] > 0);
      chk("R4 model busy", 32'(busy), 32'(m_busy));
      chk("R6 model hold", 32'(ch_hold), 32'(m_hold()));
      chk("R8 model reset-busy", 32'(ch_rst_busy), 32'(m_rb));
      chk("R1 model rdata", 32'(host_rdata), 32'(m_rdata));
    end
  end

  // ---------------- host tasks ----------------
  task automatic hw(input logic [2:0] a, input logic [15:0] d);
    host_addr = a; host_wdata = d; host_wr = 1'b1;
    @(negedge clk);
    host_wr = 1'b0;
  endtask

  task automatic hr(input logic [2:0] a, output logic [15:0] v);
    host_addr = a; host_rd = 1'b1;
    @(negedge clk);
    host_rd = 1'b0;
    v = host_rdata;
  endtask

  task automatic xwr(input logic [15:0] xa, input logic [31:0] d);
    int n = 0;
    hw(3'd0, d[15:0]); hw(3'd1, d[31:16]); hw(3'd2, xa);
    while (busy) begin n++; @(negedge clk); end
    chk("R4 busy length", 32'(n), 32'd4);
  endtask

  task automatic xrd(input logic [15:0] xa, output logic [31:0] v);
    logic [15:0] lo, hi;
    hw(3'd3, xa);
    while (busy) @(negedge clk);
    hr(3'd0, lo); hr(3'd1, hi);
    v = {hi, lo};
  endtask

  task automatic count_rb(input int c, output int n);
    n = 0;
    while (ch_rst_busy[c]) begin n++; @(negedge clk); end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [31:0] v;
    logic [15:0] s;
    int n;
    repeat (3) @(negedge clk);
    chk("R11 busy in reset", 32'(busy), 32'd0);
    chk("R11 hold in reset", 32'(ch_hold), 32'd0);
    rst = 1'b0;
    @(negedge clk);
    chk("R11 reset-busy after reset", 32'(ch_rst_busy), 32'hF);
    hr(3'd0, s);
    chk("R11 read hold cleared", 32'(s), 32'd0);
    repeat (40) @(negedge clk);
    chk("R11 reset-busy expired", 32'(ch_rst_busy), 32'd0);

    xwr(16'h0003, 32'h12345678);
    xrd(16'h0003, v);
    chk("R2 R3 write then read back", v, 32'h12345678);
    xwr(16'h3003, 32'hA5A55A5A);
    xrd(16'h0003, v);
    chk("R2 other channel untouched", v, 32'h12345678);
    xrd(16'h3003, v);
    chk("R3 channel 3 read", v, 32'hA5A55A5A);

    xwr(16'h0012, 32'hDEADBEEF);
    xrd(16'h0012, v);
    chk("R10 narrow register", v, 32'h0000BEEF);

    xwr(16'h1805, 32'hCAFEF00D);
    xrd(16'h1805, v);
    chk("R7 RAM read without hold", v, 32'h0);
    xwr(16'h100A, 32'h80000000);
    chk("R6 hold set", 32'(ch_hold), 32'h2);
    xrd(16'h1805, v);
    chk("R7 ignored write left no data", v, 32'h0);
    xwr(16'h1805, 32'hCAFEF00D);
    xrd(16'h1805, v);
    chk("R7 RAM write with hold", v, 32'hCAFEF00D);
    xwr(16'h100A, 32'h0);
    chk("R6 hold cleared", 32'(ch_hold), 32'h0);
    count_rb(1, n);
    chk("R8 release reset length", 32'(n), 32'd32);
    xrd(16'h1805, v);
    chk("R7 RAM read after release", v, 32'h0);

    xwr(16'h2019, 32'h1);
    chk("R9 soft reset starts", 32'(ch_rst_busy), 32'h4);
    count_rb(2, n);
    chk("R9 soft reset length", 32'(n), 32'd32);

    hw(3'd3, 16'h3003);
    hw(3'd0, 16'hFFFF);
    hw(3'd2, 16'h0003);
    while (busy) @(negedge clk);
    xrd(16'h3003, v);
    chk("R3 read survived drops", v, 32'hA5A55A5A);
    hr(3'd4, s);
    chk("R5 error flagged", 32'(s), 32'h2);
    xrd(16'h0003, v);
    chk("R5 dropped write had no effect", v, 32'h12345678);
    hw(3'd4, 16'h0001);
    hr(3'd4, s);
    chk("R5 error cleared", 32'(s), 32'h0);

    repeat (5) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule